// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block sits between the interrupt sources of a system and a single processor. It keeps one presentation register. The upper byte holds the processor's current priority and the lower 24 bits hold the number of the source being offered. It also keeps the priority of the offered source and a priority for the software inter-processor interrupt (IPI). When sources offer interrupts, the block compares priorities. A numerically smaller value is more favoured, and 0xFF means "none". The block keeps the single best candidate and drives one interrupt line to the processor. A candidate that is displaced is handed back to its owner on a reject strobe. A resend strobe asks the source side to offer again anything that was blocked.

The processor uses the block through five request inputs:

- an offer port for sources, carrying a source number and a priority;
- a current-priority write;
- an IPI-priority write;
- an accept read, which takes the pending interrupt and raises the current priority to its level;
- an end-of-interrupt (EOI) write, which restores a priority and forwards the source number to the source side.

All state changes and strobes take effect at the clock edge that samples the request. At most one request is served per cycle.

The control core is a three-state machine:

- `PS_IDLE`: nothing pending.
- `PS_SRC`: an external source is pending; it has an owner to reject to.
- `PS_IPI`: the IPI is pending; it has no owner.

The transitions are named as follows:

- *latch*: any state to `PS_SRC`, when an offer is taken.
- *inject*: any state to `PS_IPI`, when the IPI check succeeds.
- *accept*: any state to `PS_IDLE`, on an accept read.
- *evict*: `PS_SRC` or `PS_IPI` to `PS_IDLE`, when a lowered current priority covers the pending one.

Top module: `cpu_irq_presenter`

## Requirements
- R1: After reset the presentation word reads 0x00000000, the interrupt line is low and all strobes are low. The pending priority is 0xFF, so an accept read issued straight after reset leaves the word at 0xFF000000. The IPI priority also resets to 0xFF.
- R2: An offer is taken only when its priority is numerically below the current priority (bits 31:24). If a source is already pending, the offer's priority must also be numerically below the pending priority. A taken offer places the source number in bits 23:0 and sets the pending priority to the offered value. An offer that is not taken changes nothing. Offered source numbers are nonzero and never equal to the IPI number 2.
- R3: When an offer is taken while an external source is pending, the next cycle shows a reject strobe carrying the displaced source number.
- R4: During the accept-read cycle the presentation word shows the register as it is. After that edge, the current priority equals the old pending priority, bits 23:0 are zero, the pending priority is 0xFF and the line is low.
- R5: A current-priority write with a value numerically below the present one stores it. If a source is pending and the new value is at most the pending priority, the source is dropped: bits 23:0 are cleared and the line is lowered. In that case a reject strobe carries the dropped number, unless the dropped source is the IPI. No resend is issued.
- R6: A current-priority write with a value not below the present one stores it and pulses resend. If the IPI priority is below the new current priority, the IPI check of R7 runs.
- R7: An IPI-priority write stores the value. If the value is below the current priority, the IPI check runs. The check does nothing when a source is pending whose pending priority is at most the IPI priority. Otherwise it rejects any pending external source, places 2 in bits 23:0, sets the pending priority to the IPI priority and raises the line.
- R8: An EOI write places bits 31:24 of the written word in the current-priority field. It pulses the EOI strobe with bits 23:0 of the word, pulses resend, and runs the IPI check if the IPI priority is below the new current priority. The pending source field is otherwise unchanged.
- R9: When several requests arrive in one cycle, only one is served. The rank is EOI, then accept, then current-priority write, then IPI write, then offer. The others are dropped.
- R10: Reject, resend and EOI strobes are one-cycle pulses, registered at the edge that serves the request. They are low in every cycle that follows an idle cycle.
- R11: The interrupt line is high exactly when bits 23:0 of the presentation word are nonzero. The pending priority is 0xFF exactly when those bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| offer_valid | input | 1 | A source offers an interrupt this cycle |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| cur_wr | input | 1 | Current-priority write |
| cur_wdata | input | 8 | New current priority |
| ipi_wr | input | 1 | IPI-priority write |
| ipi_wdata | input | 8 | New IPI priority |
| accept_rd | input | 1 | Accept read |
| eoi_wr | input | 1 | End-of-interrupt write |
| eoi_wdata | input | 32 | Priority to restore (31:24) and finished source (23:0) |
| pres_word | output | 32 | Presentation register: current priority and pending source |
| irq_out | output | 1 | Interrupt line to the processor |
| reject_valid | output | 1 | Reject strobe to the source side |
| reject_src | output | 24 | Rejected source number |
| resend_req | output | 1 | Resend request strobe |
| eoi_valid | output | 1 | EOI strobe to the source side |
| eoi_src | output | 24 | Source number being finished |

## Verification
The assertions watch on every cycle the coupling between the line, the source field and the "none" pending priority. They also check what follows an accept and an EOI, that a reject always names the source pending just before it, and that a raising priority write always yields a resend. Which offer wins against which, eviction against the IPI and against an external source, and the ranking of simultaneous requests can only be shown by the bench's scenarios. The bench runs a directed sequence and a long pseudo-random stream. In the stream, priorities are drawn from a small set with many equal values, and each step is compared with a reference model built from the requirements.

// File: rtl/cpp_pkg.sv
package cpp_pkg;
    typedef enum logic [2:0] {
        OP_NONE,
        OP_EOI,
        OP_ACCEPT,
        OP_CUR,
        OP_IPI,
        OP_OFFER
    } op_e;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_SRC,
        PS_IPI
    } pres_st_e;
endpackage

// File: rtl/cpp_op_select.sv
module cpp_op_select (
    input  logic           eoi_wr,
    input  logic           accept_rd,
    input  logic           cur_wr,
    input  logic           ipi_wr,
    input  logic           offer_valid,
    output cpp_pkg::op_e   op
);
    always_comb begin
        if (eoi_wr)           op = cpp_pkg::OP_EOI;
        else if (accept_rd)   op = cpp_pkg::OP_ACCEPT;
        else if (cur_wr)      op = cpp_pkg::OP_CUR;
        else if (ipi_wr)      op = cpp_pkg::OP_IPI;
        else if (offer_valid) op = cpp_pkg::OP_OFFER;
        else                  op = cpp_pkg::OP_NONE;
    end
endmodule

// File: rtl/cpp_offer_filter.sv
module cpp_offer_filter #(
    parameter int PRIO_W = 8
) (
    input  logic              pending,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic [PRIO_W-1:0] offer_prio,
    output logic              take
);
    always_comb begin
        take = (offer_prio < cur_prio) && (!pending || (offer_prio < pend_prio));
    end
endmodule

// File: rtl/cpp_ipi_check.sv
module cpp_ipi_check #(
    parameter int PRIO_W = 8
) (
    input  logic              run,
    input  logic              pending,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic [PRIO_W-1:0] ipi_prio,
    output logic              take
);
    always_comb begin
        take = run && !(pending && (pend_prio <= ipi_prio));
    end
endmodule

// File: rtl/cpu_irq_presenter.sv
module cpu_irq_presenter #(
    parameter int PRIO_W  = 8,
    parameter int SRC_W   = 24,
    parameter int IPI_SRC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      offer_valid,
    input  logic [SRC_W-1:0]          offer_src,
    input  logic [PRIO_W-1:0]         offer_prio,
    input  logic                      cur_wr,
    input  logic [PRIO_W-1:0]         cur_wdata,
    input  logic                      ipi_wr,
    input  logic [PRIO_W-1:0]         ipi_wdata,
    input  logic                      accept_rd,
    input  logic                      eoi_wr,
    input  logic [PRIO_W+SRC_W-1:0]   eoi_wdata,
    output logic [PRIO_W+SRC_W-1:0]   pres_word,
    output logic                      irq_out,
    output logic                      reject_valid,
    output logic [SRC_W-1:0]          reject_src,
    output logic                      resend_req,
    output logic                      eoi_valid,
    output logic [SRC_W-1:0]          eoi_src
);
    import cpp_pkg::*;

    localparam int                WORD_W    = PRIO_W + SRC_W;
    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
    localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);

    pres_st_e          st_q, st_n;
    logic [PRIO_W-1:0] cur_q, cur_n;
    logic [PRIO_W-1:0] pp_q, pp_n;
    logic [PRIO_W-1:0] ipi_q, ipi_n;
    logic [SRC_W-1:0]  src_q, src_n;

    op_e               op;
    logic              pending;
    logic              offer_take;
    logic              ipi_take;
    logic              cur_lower;
    logic              chk_run;
    logic [PRIO_W-1:0] chk_ipi;
    logic [PRIO_W-1:0] chk_cur;
    logic              rej_n, res_n, eoi_n;

    assign pending   = (st_q != PS_IDLE);
    assign cur_lower = (cur_wdata < cur_q);
    assign pres_word = {cur_q, src_q};

    cpp_op_select u_sel (
        .eoi_wr      (eoi_wr),
        .accept_rd   (accept_rd),
        .cur_wr      (cur_wr),
        .ipi_wr      (ipi_wr),
        .offer_valid (offer_valid),
        .op          (op)
    );

    cpp_offer_filter #(.PRIO_W(PRIO_W)) u_filt (
        .pending    (pending),
        .pend_prio  (pp_q),
        .cur_prio   (cur_q),
        .offer_prio (offer_prio),
        .take       (offer_take)
    );

    // Operands of the single IPI check, selected by the request being served
    always_comb begin
        chk_ipi = (op == OP_IPI) ? ipi_wdata : ipi_q;
        unique case (op)
            OP_EOI:  chk_cur = eoi_wdata[WORD_W-1:SRC_W];
            OP_CUR:  chk_cur = cur_wdata;
            default: chk_cur = cur_q;
        endcase
        chk_run = ((op == OP_IPI) || (op == OP_EOI) || ((op == OP_CUR) && !cur_lower))
                  && (chk_ipi < chk_cur);
    end

    cpp_ipi_check #(.PRIO_W(PRIO_W)) u_ipi (
        .run       (chk_run),
        .pending   (pending),
        .pend_prio (pp_q),
        .ipi_prio  (chk_ipi),
        .take      (ipi_take)
    );

    // Next-state logic
    always_comb begin
        st_n  = st_q;
        cur_n = cur_q;
        pp_n  = pp_q;
        ipi_n = ipi_q;
        src_n = src_q;
        rej_n = 1'b0;
        res_n = 1'b0;
        eoi_n = 1'b0;
        unique case (op)
            OP_OFFER: begin
                if (offer_take) begin            // latch
                    rej_n = (st_q == PS_SRC);
                    src_n = offer_src;
                    pp_n  = offer_prio;
                    st_n  = PS_SRC;
                end
            end
            OP_ACCEPT: begin                     // accept
                cur_n = pp_q;
                src_n = '0;
                pp_n  = PRIO_NONE;
                st_n  = PS_IDLE;
            end
            OP_CUR: begin
                cur_n = cur_wdata;
                if (cur_lower) begin
                    if (pending && (cur_wdata <= pp_q)) begin   // evict
                        rej_n = (st_q == PS_SRC);
                        src_n = '0;
                        pp_n  = PRIO_NONE;
                        st_n  = PS_IDLE;
                    end
                end else begin
                    res_n = 1'b1;
                end
            end
            OP_IPI: begin
                ipi_n = ipi_wdata;
            end
            OP_EOI: begin
                cur_n = eoi_wdata[WORD_W-1:SRC_W];
                eoi_n = 1'b1;
                res_n = 1'b1;
            end
            default: begin
            end
        endcase
        if (ipi_take) begin                      // inject
            rej_n = (st_q == PS_SRC);
            src_n = IPI_NUM;
            pp_n  = chk_ipi;
            st_n  = PS_IPI;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PS_IDLE;
            cur_q <= '0;
            pp_q  <= PRIO_NONE;
            ipi_q <= PRIO_NONE;
            src_q <= '0;
        end else begin
            st_q  <= st_n;
            cur_q <= cur_n;
            pp_q  <= pp_n;
            ipi_q <= ipi_n;
            src_q <= src_n;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_out      <= 1'b0;
            reject_valid <= 1'b0;
            reject_src   <= '0;
            resend_req   <= 1'b0;
            eoi_valid    <= 1'b0;
            eoi_src      <= '0;
        end else begin
            irq_out      <= (st_n != PS_IDLE);
            reject_valid <= rej_n;
            reject_src   <= src_q;
            resend_req   <= res_n;
            eoi_valid    <= eoi_n;
            eoi_src      <= eoi_wdata[SRC_W-1:0];
        end
    end
endmodule

// File: rtl/cpu_irq_presenter_chk.sv
module cpu_irq_presenter_chk #(
    parameter int PRIO_W = 8,
    parameter int SRC_W  = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    accept_rd,
    input logic                    eoi_wr,
    input logic [PRIO_W+SRC_W-1:0] eoi_wdata,
    input logic                    cur_wr,
    input logic [PRIO_W-1:0]       cur_wdata,
    input logic [PRIO_W+SRC_W-1:0] pres_word,
    input logic                    irq_out,
    input logic                    reject_valid,
    input logic [SRC_W-1:0]        reject_src,
    input logic                    resend_req,
    input logic                    eoi_valid,
    input logic [SRC_W-1:0]        eoi_src,
    input logic [PRIO_W-1:0]       pp_q
);
    localparam int W = PRIO_W + SRC_W;

    assert_line_tracks_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (pres_word[SRC_W-1:0] != '0));

    assert_none_prio_when_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pres_word[SRC_W-1:0] == '0) == (pp_q == '1));

    assert_accept_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_rd && !eoi_wr) |=> (!irq_out && (pres_word[SRC_W-1:0] == '0)
                                    && (pres_word[W-1:SRC_W] == $past(pp_q))));

    assert_eoi_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_wr |=> (eoi_valid && resend_req && (eoi_src == $past(eoi_wdata[SRC_W-1:0]))
                    && (pres_word[W-1:SRC_W] == $past(eoi_wdata[W-1:SRC_W]))));

    assert_reject_names_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reject_valid |-> ($past(irq_out) && (reject_src == $past(pres_word[SRC_W-1:0]))));

    assert_raise_resends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_wr && !eoi_wr && !accept_rd && (cur_wdata >= pres_word[W-1:SRC_W])) |=> resend_req);
endmodule

bind cpu_irq_presenter cpu_irq_presenter_chk #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_rd    (accept_rd),
    .eoi_wr       (eoi_wr),
    .eoi_wdata    (eoi_wdata),
    .cur_wr       (cur_wr),
    .cur_wdata    (cur_wdata),
    .pres_word    (pres_word),
    .irq_out      (irq_out),
    .reject_valid (reject_valid),
    .reject_src   (reject_src),
    .resend_req   (resend_req),
    .eoi_valid    (eoi_valid),
    .eoi_src      (eoi_src),
    .pp_q         (pp_q)
);

// File: tb/cpu_irq_presenter_tb.sv
module cpu_irq_presenter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_src = '0;
    logic [7:0]  offer_prio = '0;
    logic        cur_wr = 1'b0;
    logic [7:0]  cur_wdata = '0;
    logic        ipi_wr = 1'b0;
    logic [7:0]  ipi_wdata = '0;
    logic        accept_rd = 1'b0;
    logic        eoi_wr = 1'b0;
    logic [31:0] eoi_wdata = '0;
    logic [31:0] pres_word;
    logic        irq_out, reject_valid, resend_req, eoi_valid;
    logic [23:0] reject_src, eoi_src;

    always #10 clk = ~clk;

    cpu_irq_presenter u_dut (
        .clk(clk), .rst_n(rst_n),
        .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
        .cur_wr(cur_wr), .cur_wdata(cur_wdata),
        .ipi_wr(ipi_wr), .ipi_wdata(ipi_wdata),
        .accept_rd(accept_rd), .eoi_wr(eoi_wr), .eoi_wdata(eoi_wdata),
        .pres_word(pres_word), .irq_out(irq_out),
        .reject_valid(reject_valid), .reject_src(reject_src),
        .resend_req(resend_req), .eoi_valid(eoi_valid), .eoi_src(eoi_src)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // reference state, from the requirements
    logic [7:0]  m_cur, m_pp, m_ipi;
    logic [23:0] m_src;
    bit          m_ext;
    bit          e_rej, e_res, e_eoi;
    logic [23:0] e_rej_src, e_eoi_src;
    logic [31:0] rng = 32'h1234_5678;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic m_ipi_check(input logic [7:0] mf);
        if (m_src != 0 && m_pp <= mf) return;
        if (m_src != 0 && m_ext) begin
            e_rej = 1; e_rej_src = m_src;
        end
        m_src = 24'd2; m_pp = mf; m_ext = 0;
    endtask

    task automatic run_op(bit de, bit da, bit dc, bit di, bit dp,
                          logic [31:0] ew, logic [7:0] cw, logic [7:0] iw,
                          logic [7:0] op_prio, logic [23:0] os);
        string tag;
        @(negedge clk);
        eoi_wr = de; eoi_wdata = ew; accept_rd = da; cur_wr = dc; cur_wdata = cw;
        ipi_wr = di; ipi_wdata = iw; offer_valid = dp; offer_prio = op_prio; offer_src = os;
        #1;
        e_rej = 0; e_res = 0; e_eoi = 0; e_rej_src = 0; e_eoi_src = 0;
        tag = "R2";
        if (da && !de) check("R4 read value", pres_word, {m_cur, m_src});
        if (de) begin
            tag = "R8";
            m_cur = ew[31:24]; e_eoi = 1; e_eoi_src = ew[23:0];
            if (m_ipi < m_cur) m_ipi_check(m_ipi);
            e_res = 1;
        end else if (da) begin
            tag = "R4";
            m_cur = m_pp; m_src = 0; m_pp = 8'hFF; m_ext = 0;
        end else if (dc) begin
            if (cw < m_cur) begin
                tag = "R5";
                m_cur = cw;
                if (m_src != 0 && cw <= m_pp) begin
                    if (m_ext) begin e_rej = 1; e_rej_src = m_src; end
                    m_src = 0; m_pp = 8'hFF; m_ext = 0;
                end
            end else begin
                tag = "R6";
                m_cur = cw;
                if (m_ipi < m_cur) m_ipi_check(m_ipi);
                e_res = 1;
            end
        end else if (di) begin
            tag = "R7";
            m_ipi = iw;
            if (iw < m_cur) m_ipi_check(iw);
        end else if (dp) begin
            if (!(op_prio >= m_cur || (m_src != 0 && m_pp <= op_prio))) begin
                if (m_src != 0 && m_ext) begin
                    tag = "R3"; e_rej = 1; e_rej_src = m_src;
                end
                m_src = os; m_pp = op_prio; m_ext = 1;
            end
        end
        if (int'(de) + int'(da) + int'(dc) + int'(di) + int'(dp) > 1) tag = "R9";
        @(negedge clk);
        eoi_wr = 0; accept_rd = 0; cur_wr = 0; ipi_wr = 0; offer_valid = 0;
        check({tag, " word"}, pres_word, {m_cur, m_src});
        check("R11 line", {31'd0, irq_out}, {31'd0, m_src != 0});
        check({tag, " reject"}, {31'd0, reject_valid}, {31'd0, e_rej});
        if (e_rej) check({tag, " reject src"}, {8'd0, reject_src}, {8'd0, e_rej_src});
        check({tag, " resend"}, {31'd0, resend_req}, {31'd0, e_res});
        check({tag, " eoi"}, {31'd0, eoi_valid}, {31'd0, e_eoi});
        if (e_eoi) check("R8 eoi src", {8'd0, eoi_src}, {8'd0, e_eoi_src});
        @(negedge clk);
        check("R10 strobes idle", {29'd0, reject_valid, resend_req, eoi_valid}, 32'd0);
    endtask

    function automatic logic [7:0] pick(input logic [3:0] b);
        return b[3] ? 8'hFF : {5'd0, b[2:0]};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_cur = 0; m_pp = 8'hFF; m_ipi = 8'hFF; m_src = 0; m_ext = 0;
        repeat (3) @(negedge clk);
        check("R1 word", pres_word, 32'h0);
        check("R1 line and strobes", {28'd0, irq_out, reject_valid, resend_req, eoi_valid}, 32'd0);
        rst_n = 1'b1;
        // offer masked by reset priority 0
        run_op(0, 0, 0, 0, 1, 0, 0, 0, 8'h00, 24'h77);
        check("R2 masked at reset", pres_word, 32'h0);
        run_op(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R1 accept after reset", pres_word, 32'hFF00_0000);
        run_op(0, 0, 0, 0, 1, 0, 0, 0, 8'h05, 24'h10);
        check("R2 taken", pres_word, 32'hFF00_0010);
        run_op(0, 0, 0, 0, 1, 0, 0, 0, 8'h05, 24'h11);
        check("R2 equal ignored", pres_word, 32'hFF00_0010);
        run_op(0, 0, 0, 0, 1, 0, 0, 0, 8'h03, 24'h12);
        check("R3 preempted", pres_word, 32'hFF00_0012);
        run_op(0, 0, 1, 0, 0, 0, 8'h03, 0, 0, 0);
        check("R5 evicted", pres_word, 32'h0300_0000);
        run_op(0, 0, 0, 1, 0, 0, 0, 8'h01, 0, 0);
        check("R7 ipi in", pres_word, 32'h0300_0002);
        run_op(0, 0, 1, 0, 0, 0, 8'h01, 0, 0, 0);
        check("R5 ipi evicted", pres_word, 32'h0100_0000);
        run_op(1, 0, 0, 0, 0, 32'h0400_0012, 0, 0, 0, 0);
        check("R8 ipi again", pres_word, 32'h0400_0002);
        run_op(0, 0, 1, 0, 0, 0, 8'hFF, 0, 0, 0);
        run_op(0, 1, 1, 1, 1, 0, 8'h00, 8'h00, 8'h00, 24'h55);
        check("R9 accept wins", pres_word, 32'h0100_0000);
        for (int k = 0; k < 4000; k++) begin
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            run_op(rng[0] & rng[1] & rng[2], rng[3] & rng[4], rng[5] & rng[6],
                   rng[7] & rng[8], rng[9] | rng[10],
                   {pick(rng[14:11]), 16'h0, rng[22:15]},
                   pick(rng[18:15]), pick(rng[22:19]), pick(rng[26:23]),
                   {16'h0001, rng[31:24]});
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule